// File: doc/BRIEF.md
# Flash Program/Erase Status Word Generator

This block is the device-side logic of a parallel NOR flash that places a status word on the data bus while an embedded program or erase is in progress. It tracks the kind of operation that is running, the block or blocks it targets and whether an erase has been suspended. From this it decides, for each bus read, whether the read returns status or falls through to the array. When it returns status, it builds an 8-bit word from three flags: a data-polling bit, a toggle bit that flips once per read, and a sticky failure bit.

A command decoder, which is not part of this block, issues operations through a one-cycle command code. A behavioural embedded controller reports completion or failure through single-cycle events. An operation aimed at a protected block is aborted without raising an error, and the block stays busy for a fixed window sized in clock cycles from the clock frequency. Erase suspend takes effect after a fixed latency. While suspended, only reads that fall inside the blocks being erased return status.

Top module: `flash_stat_top`

## Requirements
- R1: In the running, suspending, aborting and failed states, `busy` is 1 and every read returns status (`status_oe`=1) whatever the block addressed.
- R2: While a program runs, status bit 7 is the inverse of the data bit being programmed.
- R3: While a block erase or a chip erase runs, status bit 7 is 0.
- R4: A `ctl_done` event during a running operation returns the block to read mode: `busy`=0 and reads give `status_oe`=0.
- R5: A suspend request during an erase keeps `busy` at 1 for SUSP_LAT_CYC cycles. After that, reads inside the erased blocks give bit 7 = 1 with `busy`=0.
- R6: While suspended, reads outside the blocks being erased give `status_oe`=0. A chip erase counts every block as being erased.
- R7: Status bit 6 is 0 after reset. It flips once at each falling edge of `rd_stb` while `busy` is 1, and it holds at all other times, including during suspend.
- R8: A resume request while suspended restarts the erase: `busy`=1, bit 7 = 0, and bit 6 toggles again.
- R9: A block erase to a protected block, or a chip erase when every block is protected, aborts with no error bit. `busy` stays at 1 for ERASE_ABORT_US×CLK_MHZ cycles, and the block then returns to read mode.
- R10: A program to a protected block, or to a block being erased while suspended, aborts for PROG_ABORT_US×CLK_MHZ cycles with no error bit. An abort that started in suspend returns to suspend.
- R11: `ctl_fail` during a running operation sets status bit 5. The bit stays set, and new commands and `ctl_done` are ignored, until `clr_err` returns the block to read mode with bit 5 clear.
- R12: Status bits 4..0 are always 0, and `status` is 0 whenever `status_oe` is 0. A synchronous reset returns the block to read mode with no error.
- R13: A suspend request during a program is ignored. While suspended, a program to an unprotected block outside the erased set is ignored. Command codes: 1 program, 2 block erase, 3 chip erase, 0 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Bus read strobe, high for the duration of a read |
| rd_blk | input | BLK_W | Block index of the read address |
| op_cmd | input | 2 | One-cycle command code: 0 none, 1 program, 2 block erase, 3 chip erase |
| op_blk | input | BLK_W | Target block of the command |
| op_bit | input | 1 | Data bit 7 being programmed |
| susp_req | input | 1 | Erase suspend request pulse |
| resume_req | input | 1 | Erase resume request pulse |
| prot_map | input | NBLK | Per-block protection flags |
| ctl_done | input | 1 | Controller reports successful completion |
| ctl_fail | input | 1 | Controller reports a write failure |
| clr_err | input | 1 | Read/reset command after a failure |
| status_oe | output | 1 | Current read returns the status word |
| status | output | 8 | Status word: bit 7 data polling, bit 6 toggle, bit 5 error |
| busy | output | 1 | An embedded operation, abort window or failure is pending |

## Verification
A wrong state in the sequencer shows up on the very next read. It appears as a flipped `status_oe` for an address inside or outside the erased set, or as a wrong bit 7. A wrong toggle register shows up only across a pair of reads, so the bench tracks the expected toggle value from read to read. Errors in the abort and suspend counters show only in the length of the `busy` window, so those windows are measured to the exact cycle.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_PROG   = 2'd1,
        CMD_BERASE = 2'd2,
        CMD_CERASE = 2'd3
    } op_cmd_e;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_RUN     = 3'd1,
        ST_SUSPING = 3'd2,
        ST_SUSP    = 3'd3,
        ST_ABORT   = 3'd4,
        ST_FAIL    = 3'd5
    } fsm_e;

    typedef struct packed {
        logic       dpoll;
        logic       tgl;
        logic       err;
        logic [4:0] rsvd;
    } status_t;

    function automatic logic is_busy(input fsm_e s);
        return (s == ST_RUN) || (s == ST_SUSPING) || (s == ST_ABORT) || (s == ST_FAIL);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/flash_stat_seq.sv
module flash_stat_seq
    import flash_stat_pkg::*;
#(
    parameter int NBLK           = 32,
    parameter int CLK_MHZ        = 250,
    parameter int ERASE_ABORT_US = 100,
    parameter int PROG_ABORT_US  = 1,
    parameter int SUSP_LAT_CYC   = 16,
    localparam int BLK_W         = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  op_cmd_e          cmd,
    input  logic [BLK_W-1:0] op_blk,
    input  logic             op_bit,
    input  logic             susp_req,
    input  logic             resume_req,
    input  logic [NBLK-1:0]  prot_map,
    input  logic             ctl_done,
    input  logic             ctl_fail,
    input  logic             clr_err,
    output fsm_e             st,
    output op_cmd_e          cur_kind,
    output logic             pbit,
    output logic [NBLK-1:0]  era_mask
);

    localparam int ERASE_CYC = ERASE_ABORT_US * CLK_MHZ;
    localparam int PROG_CYC  = PROG_ABORT_US * CLK_MHZ;
    localparam int CNT_TOP   = max3(ERASE_CYC, PROG_CYC, SUSP_LAT_CYC);
    localparam int CNT_W     = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] SUSP_LD  = CNT_W'(SUSP_LAT_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             back_susp;
    op_cmd_e          era_kind;
    logic [NBLK-1:0]  blk_sel;
    logic             tgt_prot;
    logic             all_prot;

    assign blk_sel  = NBLK'(1) << op_blk;
    assign tgt_prot = prot_map[op_blk];
    assign all_prot = &prot_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_READ;
            cnt       <= '0;
            cur_kind  <= CMD_NONE;
            era_kind  <= CMD_NONE;
            pbit      <= 1'b0;
            era_mask  <= '0;
            back_susp <= 1'b0;
        end else begin
            case (st)
                ST_READ: begin
                    case (cmd)
                        CMD_PROG: begin
                            cur_kind <= CMD_PROG;
                            pbit     <= op_bit;
                            if (tgt_prot) begin
                                st        <= ST_ABORT;
                                cnt       <= PROG_LD;
                                back_susp <= 1'b0;
                            end else begin
                                st <= ST_RUN;
                            end
                        end
                        CMD_BERASE: begin
                            cur_kind <= CMD_BERASE;
                            era_kind <= CMD_BERASE;
                            era_mask <= blk_sel;
                            if (tgt_prot) begin
                                st        <= ST_ABORT;
                                cnt       <= ERASE_LD;
                                back_susp <= 1'b0;
                            end else begin
                                st <= ST_RUN;
                            end
                        end
                        CMD_CERASE: begin
                            cur_kind <= CMD_CERASE;
                            era_kind <= CMD_CERASE;
                            era_mask <= '1;
                            if (all_prot) begin
                                st        <= ST_ABORT;
                                cnt       <= ERASE_LD;
                                back_susp <= 1'b0;
                            end else begin
                                st <= ST_RUN;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_RUN: begin
                    if (ctl_fail) begin
                        st <= ST_FAIL;
                    end else if (ctl_done) begin
                        st <= ST_READ;
                    end else if (susp_req && (cur_kind != CMD_PROG)) begin
                        st  <= ST_SUSPING;
                        cnt <= SUSP_LD;
                    end
                end
                ST_SUSPING: begin
                    if (ctl_fail) begin
                        st <= ST_FAIL;
                    end else if (ctl_done) begin
                        st <= ST_READ;
                    end else if (cnt == '0) begin
                        st <= ST_SUSP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (resume_req) begin
                        st       <= ST_RUN;
                        cur_kind <= era_kind;
                    end else if ((cmd == CMD_PROG) && (era_mask[op_blk] || tgt_prot)) begin
                        st        <= ST_ABORT;
                        cnt       <= PROG_LD;
                        back_susp <= 1'b1;
                        cur_kind  <= CMD_PROG;
                        pbit      <= op_bit;
                    end
                end
                ST_ABORT: begin
                    if (cnt == '0) begin
                        st <= back_susp ? ST_SUSP : ST_READ;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_FAIL: begin
                    if (clr_err) begin
                        st <= ST_READ;
                    end
                end
                default: st <= ST_READ;
            endcase
        end
    end

endmodule

// File: rtl/flash_stat_tgl.sv
module flash_stat_tgl (
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  logic adv_en,
    output logic rd_fall,
    output logic tgl_q
);

    logic rd_q;

    assign rd_fall = rd_q && !rd_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            tgl_q <= 1'b0;
        end else begin
            rd_q <= rd_stb;
            if (rd_fall && adv_en) begin
                tgl_q <= !tgl_q;
            end
        end
    end

endmodule

// File: rtl/flash_stat_word.sv
module flash_stat_word
    import flash_stat_pkg::*;
#(
    parameter int NBLK   = 32,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  fsm_e             st,
    input  op_cmd_e          cur_kind,
    input  logic             pbit,
    input  logic [NBLK-1:0]  era_mask,
    input  logic             tgl,
    input  logic             rd_stb,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             busy,
    output logic             status_oe,
    output status_t          word
);

    logic in_era;

    always_comb begin
        in_era    = era_mask[rd_blk];
        busy      = is_busy(st);
        status_oe = rd_stb && (busy || ((st == ST_SUSP) && in_era));
        word      = '0;
        if (status_oe) begin
            if (st == ST_SUSP) begin
                word.dpoll = 1'b1;
            end else if (cur_kind == CMD_PROG) begin
                word.dpoll = !pbit;
            end else begin
                word.dpoll = 1'b0;
            end
            word.tgl = tgl;
            word.err = (st == ST_FAIL);
        end
    end

endmodule

// File: rtl/flash_stat_top.sv
module flash_stat_top
    import flash_stat_pkg::*;
#(
    parameter int NBLK           = 32,
    parameter int CLK_MHZ        = 250,
    parameter int ERASE_ABORT_US = 100,
    parameter int PROG_ABORT_US  = 1,
    parameter int SUSP_LAT_CYC   = 16,
    localparam int BLK_W         = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_stb,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic [1:0]       op_cmd,
    input  logic [BLK_W-1:0] op_blk,
    input  logic             op_bit,
    input  logic             susp_req,
    input  logic             resume_req,
    input  logic [NBLK-1:0]  prot_map,
    input  logic             ctl_done,
    input  logic             ctl_fail,
    input  logic             clr_err,
    output logic             status_oe,
    output logic [7:0]       status,
    output logic             busy
);

    fsm_e            st;
    op_cmd_e         cur_kind;
    logic            pbit;
    logic [NBLK-1:0] era_mask;
    logic            rd_fall;
    logic            tgl_q;
    status_t         word;

    flash_stat_seq #(
        .NBLK          (NBLK),
        .CLK_MHZ       (CLK_MHZ),
        .ERASE_ABORT_US(ERASE_ABORT_US),
        .PROG_ABORT_US (PROG_ABORT_US),
        .SUSP_LAT_CYC  (SUSP_LAT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (op_cmd_e'(op_cmd)),
        .op_blk    (op_blk),
        .op_bit    (op_bit),
        .susp_req  (susp_req),
        .resume_req(resume_req),
        .prot_map  (prot_map),
        .ctl_done  (ctl_done),
        .ctl_fail  (ctl_fail),
        .clr_err   (clr_err),
        .st        (st),
        .cur_kind  (cur_kind),
        .pbit      (pbit),
        .era_mask  (era_mask)
    );

    flash_stat_tgl u_tgl (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .adv_en (busy),
        .rd_fall(rd_fall),
        .tgl_q  (tgl_q)
    );

    flash_stat_word #(
        .NBLK(NBLK)
    ) u_word (
        .st       (st),
        .cur_kind (cur_kind),
        .pbit     (pbit),
        .era_mask (era_mask),
        .tgl      (tgl_q),
        .rd_stb   (rd_stb),
        .rd_blk   (rd_blk),
        .busy     (busy),
        .status_oe(status_oe),
        .word     (word)
    );

    assign status = word;

endmodule

// File: rtl/flash_stat_chk.sv
module flash_stat_chk
    import flash_stat_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic       rd_fall,
    input logic       tgl,
    input logic       busy,
    input logic       status_oe,
    input logic [7:0] status,
    input fsm_e       st,
    input logic       ctl_fail,
    input logic       clr_err
);

    AST_BUSY_ANY_ADDR: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_stb) |-> status_oe); // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_oe |-> (status[4:0] == 5'd0)); // R12

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !status_oe |-> (status == 8'd0)); // R12

    AST_TGL_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !rd_fall |=> $stable(tgl)); // R7

    AST_SUSP_DPOLL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (status_oe && !busy) |-> (status[7] && !status[5])); // R5

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_FAIL) && !clr_err) |=> (st == ST_FAIL)); // R11

    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_FAIL) |-> $past(ctl_fail)); // R11

    AST_ABORT_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ABORT) && status_oe) |-> !status[5]); // R9

endmodule

bind flash_stat_top flash_stat_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .rd_fall  (rd_fall),
    .tgl      (tgl_q),
    .busy     (busy),
    .status_oe(status_oe),
    .status   (status),
    .st       (st),
    .ctl_fail (ctl_fail),
    .clr_err  (clr_err)
);

// File: tb/sim_flash_stat_top.sv
`timescale 1ns/1ps
module sim_flash_stat_top;

    localparam int NB   = 4;
    localparam int MHZ  = 4;
    localparam int EUS  = 100;
    localparam int PUS  = 1;
    localparam int SL   = 3;
    localparam int ECYC = EUS * MHZ;
    localparam int PCYC = PUS * MHZ;
    localparam int BW   = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_stb = 1'b0;
    logic [BW-1:0] rd_blk = '0;
    logic [1:0]    op_cmd = 2'd0;
    logic [BW-1:0] op_blk = '0;
    logic          op_bit = 1'b0;
    logic          susp_req = 1'b0;
    logic          resume_req = 1'b0;
    logic [NB-1:0] prot_map = '0;
    logic          ctl_done = 1'b0;
    logic          ctl_fail = 1'b0;
    logic          clr_err = 1'b0;
    logic          status_oe;
    logic [7:0]    status;
    logic          busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit exp_t  = 1'b0;

    always #2 clk = ~clk;

    flash_stat_top #(
        .NBLK(NB), .CLK_MHZ(MHZ), .ERASE_ABORT_US(EUS),
        .PROG_ABORT_US(PUS), .SUSP_LAT_CYC(SL)
    ) u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_blk(rd_blk),
        .op_cmd(op_cmd), .op_blk(op_blk), .op_bit(op_bit),
        .susp_req(susp_req), .resume_req(resume_req), .prot_map(prot_map),
        .ctl_done(ctl_done), .ctl_fail(ctl_fail), .clr_err(clr_err),
        .status_oe(status_oe), .status(status), .busy(busy)
    );

    // One bus read; all tasks start and end on a falling clock edge.
    task automatic rd(input int blk, input bit eoe, input bit e7, input bit e5,
                      input bit adv, input string tag);
        logic [7:0] exp;
        rd_stb = 1'b1;
        rd_blk = BW'(blk);
        #1;
        exp = eoe ? {e7, exp_t, e5, 5'b00000} : 8'h00;
        n_chk++;
        if (status_oe !== eoe || status !== exp) begin
            n_fail++;
            $display("FAIL %s blk=%0d: oe=%0b status=%02h expected oe=%0b status=%02h",
                     tag, blk, status_oe, status, eoe, exp);
        end
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        if (adv) exp_t = ~exp_t;
    endtask

    task automatic cmd(input logic [1:0] k, input int blk, input bit b);
        op_cmd = k;
        op_blk = BW'(blk);
        op_bit = b;
        @(negedge clk);
        op_cmd = 2'd0;
    endtask

    // 0 done, 1 fail, 2 suspend, 3 resume, 4 read/reset
    task automatic pulse(input int which);
        case (which)
            0: ctl_done = 1'b1;
            1: ctl_fail = 1'b1;
            2: susp_req = 1'b1;
            3: resume_req = 1'b1;
            default: clr_err = 1'b1;
        endcase
        @(negedge clk);
        ctl_done = 1'b0; ctl_fail = 1'b0; susp_req = 1'b0;
        resume_req = 1'b0; clr_err = 1'b0;
    endtask

    task automatic count_busy(input int expn, input string tag);
        int n;
        n = 0;
        forever begin
            #1;
            if (!busy || n > 100000) break;
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        n_chk++;
        if (n != expn) begin
            n_fail++;
            $display("FAIL %s: busy cycles=%0d expected=%0d", tag, n, expn);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        n_chk++;
        if (busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset busy: actual=%0b expected=0", busy);
        end
        rd(0, 0, 0, 0, 0, "R12 reset read");

        // R1 R2 R7: program sweep over blocks, data values and read addresses
        for (int b = 0; b < NB; b++) begin
            for (int v = 0; v < 2; v++) begin
                cmd(2'd1, b, v[0]);
                for (int a = 0; a < NB; a++)
                    rd(a, 1, ~v[0], 0, 1, "R1 R2 R7 program status");
                if (b == 0) begin
                    pulse(2);
                    rd(b, 1, ~v[0], 0, 1, "R13 suspend ignored in program");
                end
                pulse(0);
                rd(b, 0, 0, 0, 0, "R4 read mode after program");
            end
        end

        // R3 R5 R6 R8 R10 R13: block erase with suspend
        for (int b = 0; b < NB; b++) begin
            cmd(2'd2, b, 1'b0);
            for (int a = 0; a < NB; a++)
                rd(a, 1, 0, 0, 1, "R3 block erase status");
            pulse(2);
            count_busy(SL, "R5 suspend latency");
            for (int a = 0; a < NB; a++)
                rd(a, a == b, 1, 0, 0, "R5 R6 suspended read");
            rd(b, 1, 1, 0, 0, "R7 toggle frozen in suspend");
            cmd(2'd1, b, 1'b1);
            count_busy(PCYC, "R10 program to suspended block");
            rd(b, 1, 1, 0, 0, "R10 back to suspend");
            cmd(2'd1, (b + 1) % NB, 1'b0);
            rd((b + 1) % NB, 0, 0, 0, 0, "R13 program outside erase ignored");
            pulse(3);
            rd((b + 2) % NB, 1, 0, 0, 1, "R8 resumed erase");
            rd(b, 1, 0, 0, 1, "R8 toggle resumed");
            pulse(0);
            rd(b, 0, 0, 0, 0, "R4 read mode after erase");
        end

        // R6: chip erase suspended covers all blocks
        cmd(2'd3, 0, 1'b0);
        rd(2, 1, 0, 0, 1, "R3 chip erase status");
        pulse(2);
        count_busy(SL, "R5 chip suspend latency");
        for (int a = 0; a < NB; a++)
            rd(a, 1, 1, 0, 0, "R6 chip suspend all blocks");
        pulse(3);
        pulse(0);
        rd(1, 0, 0, 0, 0, "R4 read mode after chip erase");

        // R9 R10: protected targets
        prot_map = 4'b0010;
        cmd(2'd2, 1, 1'b0);
        rd(3, 1, 0, 0, 1, "R9 erase abort no error");
        count_busy(ECYC - 2, "R9 erase abort window");
        rd(1, 0, 0, 0, 0, "R9 read mode after abort");
        cmd(2'd1, 1, 1'b1);
        count_busy(PCYC, "R10 protected program window");
        cmd(2'd2, 0, 1'b0);
        rd(1, 1, 0, 0, 1, "R9 unprotected erase runs");
        pulse(0);
        prot_map = 4'b1111;
        cmd(2'd3, 0, 1'b0);
        count_busy(ECYC, "R9 chip erase all protected");
        prot_map = 4'b0010;
        cmd(2'd3, 0, 1'b0);
        rd(0, 1, 0, 0, 1, "R9 chip erase partial protection runs");
        pulse(0);
        prot_map = '0;

        // R11: failure handling
        cmd(2'd1, 2, 1'b0);
        pulse(1);
        rd(0, 1, 1, 1, 1, "R11 error bit set");
        cmd(2'd2, 3, 1'b0);
        rd(3, 1, 1, 1, 1, "R11 command ignored after error");
        pulse(0);
        rd(1, 1, 1, 1, 1, "R11 done ignored after error");
        pulse(4);
        rd(2, 0, 0, 0, 0, "R11 read/reset clears");
        cmd(2'd1, 0, 1'b1);
        rd(0, 1, 0, 0, 1, "R11 error bit clear on new program");
        pulse(0);

        // R12: reset during an erase
        cmd(2'd2, 0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_t = 1'b0;
        rd(0, 0, 0, 0, 0, "R12 reset aborts operation");
        cmd(2'd1, 3, 1'b1);
        rd(3, 1, 0, 0, 1, "R12 toggle cleared by reset");
        pulse(0);

        summary();
        $finish;
    end

endmodule